// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a synthesizer's input clock by a programmable ratio of P·N + A. A dual-modulus prescaler, modelled as a digital down-counter, divides by either P or P+1. A swallow counter keeps the prescaler at P+1 for the first A prescaler cycles of each period. A main counter then ends the period after N prescaler cycles in total. At that point the block raises the comparison pulse `fp` for one input clock, and every counter reloads.

The values N and A, and the choice of P, are sampled only at a reload boundary, so a change in the middle of a period never produces a mixed-length period. A select bit picks P = 64 (bit high) or P = 128 (bit low). A parameter gives a fixed-modulus build instead, for example 16/17. The `mod_ctl` output shows which modulus the prescaler is using. The first enabled cycle after reset loads the counters and does not produce a pulse. Callers must keep N at 5 or more and A below N; the block itself does not check whether a setting is legal.

Top module: `pswallow_div`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `fp` and `mod_ctl` are 0. The first enabled cycle after reset loads the counters without an `fp` pulse, and the first pulse comes P·N+A enabled cycles later.
- R2: With `mod_sel` = 1 (P = 64), `fp` pulses every 64·N+A enabled cycles. Each pulse lasts exactly one cycle and is visible in the cycle after the last input cycle of the period.
- R3: With `mod_sel` = 0 (P = 128), `fp` pulses every 128·N+A enabled cycles.
- R4: `mod_ctl` is 1 for the first A·(P+1) input cycles of each period, counted from the `fp` cycle, and 0 for the rest. It only falls at the end of a prescaler cycle.
- R5: With A = 0, `mod_ctl` stays 0 for the whole period and the period is P·N cycles.
- R6: New `n_val`, `a_val` and `mod_sel` values written during a period have no effect on that period. They apply from the period that begins with the next `fp` pulse.
- R7: While `en` is 0, no counter advances, `fp` is 0 and `mod_ctl` holds its value. A period that contains k disabled cycles spans P·N+A+k cycles.
- R8: Edge settings divide correctly: N = 5 with A = 4, and N = 128 with A = 127.
- R9: A build with the fixed-modulus parameter set to 4 divides by 16·N+A regardless of `mod_sel`. N = 291 with A = 7 gives 4663 cycles, with `mod_ctl` high for 119 of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; when low, all counters freeze |
| n_val | input | 11 | Main counter setting N (5 to 2047) |
| a_val | input | 7 | Swallow counter setting A (0 to 127, less than N) |
| mod_sel | input | 1 | Modulus pick: 1 gives 64/65, 0 gives 128/129 |
| fp | output | 1 | One-cycle comparison pulse at each period end |
| mod_ctl | output | 1 | 1 while the prescaler divides by P+1 |

## Verification
The last input cycle of a period is consumed at one rising edge, and `fp` is visible right after that edge. It lasts one cycle, and the reload that takes the new N, A and P happens at that same edge. `mod_ctl` updates at the edge that closes a prescaler cycle. A changed input therefore shows its effect in the `fp` interval that starts with the next pulse, not in the current one. The bench runs a cycle-level behavioural model that sees the same inputs at each rising edge, and compares it with both instances at every falling edge. It also measures complete `fp`-to-`fp` intervals and counts the `mod_ctl` high cycles inside each interval. These interval checks start counting on the falling edge where `fp` is seen.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  localparam int FN_W = 16;

  // Divide value of a power-of-two modulus given its log2
  function automatic logic [FN_W-1:0] modulus_of(input int unsigned lg);
    modulus_of = FN_W'(1) << lg;
  endfunction

  // Down-count start for the next prescaler cycle: P+1 states when a
  // swallow is still owed, otherwise P states
  function automatic logic [FN_W-1:0] presc_start(input logic [FN_W-1:0] p,
                                                   input logic owe_extra);
    presc_start = owe_extra ? p : (p - FN_W'(1));
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    max3 = (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pswallow_presc.sv
module pswallow_presc
  import pswallow_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            load,
  input  logic [PC_W-1:0] p_run,
  input  logic [PC_W-1:0] p_new,
  input  logic            a_new_nz,
  input  logic            owe_next,
  output logic            tc,
  output logic [PC_W-1:0] cnt
);

  assign tc = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= PC_W'(presc_start(FN_W'(p_new), a_new_nz));
    end else if (en) begin
      if (tc) begin
        cnt <= PC_W'(presc_start(FN_W'(p_run), owe_next));
      end else begin
        cnt <= cnt - PC_W'(1);
      end
    end
  end

endmodule

// File: rtl/pswallow_swallow.sv
module pswallow_swallow #(
  parameter int A_W = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           load,
  input  logic           presc_tc,
  input  logic [A_W-1:0] a_new,
  output logic           owe_next,
  output logic           owe_now
);

  logic [A_W-1:0] left_q;
  logic [A_W-1:0] left_d;

  assign owe_now = (left_q != '0);

  // Value after the current prescaler cycle closes
  always_comb begin
    left_d = left_q;
    if (presc_tc && owe_now) begin
      left_d = left_q - A_W'(1);
    end
  end

  assign owe_next = (left_d != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= a_new;
    end else if (en) begin
      left_q <= left_d;
    end
  end

endmodule

// File: rtl/pswallow_main.sv
module pswallow_main #(
  parameter int N_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           load,
  input  logic           presc_tc,
  input  logic [N_W-1:0] n_new,
  output logic           tc
);

  logic [N_W-1:0] rem_q;

  assign tc = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= n_new - N_W'(1);
    end else if (en && presc_tc) begin
      rem_q <= rem_q - N_W'(1);
    end
  end

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter int N_W       = 11,
  parameter int A_W       = 7,
  parameter int SEL_LOG   = 6,
  parameter int DEF_LOG   = 7,
  parameter int FIXED_LOG = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [N_W-1:0] n_val,
  input  logic [A_W-1:0] a_val,
  input  logic           mod_sel,
  output logic           fp,
  output logic           mod_ctl
);

  localparam int PC_W = max3(SEL_LOG, DEF_LOG, FIXED_LOG) + 1;

  logic [PC_W-1:0] p_new;
  logic [PC_W-1:0] p_cur;
  logic [PC_W-1:0] pc_cnt;
  logic            presc_tc;
  logic            main_tc;
  logic            owe_next;
  logic            owe_now;
  logic            load;
  logic            started_q;
  logic            fp_q;

  generate
    if (FIXED_LOG != 0) begin : g_fixed
      assign p_new = PC_W'(modulus_of(FIXED_LOG));
    end else begin : g_select
      assign p_new = mod_sel ? PC_W'(modulus_of(SEL_LOG))
                             : PC_W'(modulus_of(DEF_LOG));
    end
  endgenerate

  // Period boundary: last input cycle of the last prescaler cycle
  assign load = en && presc_tc && main_tc;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_cur     <= '0;
      started_q <= 1'b0;
      fp_q      <= 1'b0;
    end else begin
      fp_q <= load && started_q;
      if (load) begin
        p_cur     <= p_new;
        started_q <= 1'b1;
      end
    end
  end

  pswallow_presc #(.PC_W(PC_W)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .load     (load),
    .p_run    (p_cur),
    .p_new    (p_new),
    .a_new_nz (a_val != '0),
    .owe_next (owe_next),
    .tc       (presc_tc),
    .cnt      (pc_cnt)
  );

  pswallow_swallow #(.A_W(A_W)) u_swallow (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .load     (load),
    .presc_tc (presc_tc),
    .a_new    (a_val),
    .owe_next (owe_next),
    .owe_now  (owe_now)
  );

  pswallow_main #(.N_W(N_W)) u_main (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .load     (load),
    .presc_tc (presc_tc),
    .n_new    (n_val),
    .tc       (main_tc)
  );

  assign fp      = fp_q;
  assign mod_ctl = owe_now;

endmodule

// File: rtl/pswallow_chk.sv
module pswallow_chk #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic            fp,
  input logic            mod_ctl,
  input logic            load,
  input logic            presc_tc,
  input logic            main_tc,
  input logic [PC_W-1:0] pc_cnt,
  input logic [PC_W-1:0] p_cur
);

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fp && !mod_ctl));

  // R2
  fp_width_chk: assert property (@(posedge clk) disable iff (rst)
    fp |=> !fp);

  // R2
  fp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    fp |-> $past(en && presc_tc && main_tc));

  // R4
  mod_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mod_ctl) |-> $past(en && presc_tc));

  // R6
  mod_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_ctl) |-> $past(load));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!fp && $stable(mod_ctl)));

  // R3
  presc_range_chk: assert property (@(posedge clk) disable iff (rst)
    pc_cnt <= p_cur);

endmodule

bind pswallow_div pswallow_chk #(.PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .fp       (fp),
  .mod_ctl  (mod_ctl),
  .load     (load),
  .presc_tc (presc_tc),
  .main_tc  (main_tc),
  .pc_cnt   (pc_cnt),
  .p_cur    (p_cur)
);

// File: tb/pswallow_div_bench.sv
`timescale 1ns/1ps

module pswallow_ref #(
  parameter int FIX_P = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [10:0] n,
  input  logic [6:0]  a,
  input  logic        sel,
  output logic        fp_e,
  output logic        mod_e
);
  int rem = 0;
  int done = 0;
  int a_cur = 0;
  int p_cur = 0;
  bit started = 0;

  initial fp_e = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      rem = 0; done = 0; a_cur = 0; p_cur = 0; started = 0;
      fp_e <= 1'b0;
    end else begin
      fp_e <= 1'b0;
      if (en) begin
        if (rem == 0) begin
          fp_e <= started;
          started = 1;
          p_cur = (FIX_P != 0) ? FIX_P : (sel ? 64 : 128);
          a_cur = int'(a);
          rem = p_cur * int'(n) + int'(a) - 1;
          done = 0;
        end else begin
          rem--;
          done++;
        end
      end
    end
  end

  assign mod_e = started && (done < a_cur * (p_cur + 1));
endmodule

module pswallow_div_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [10:0] n_val = 11'd10;
  logic [6:0]  a_val = 7'd3;
  logic        mod_sel = 1'b1;
  logic        fp0, mod0, fp1, mod1;
  logic        efp0, emod0, efp1, emod1;

  int    checks = 0;
  int    bad = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pswallow_div u_pswallow_div (
    .clk(clk), .rst(rst), .en(en), .n_val(n_val), .a_val(a_val),
    .mod_sel(mod_sel), .fp(fp0), .mod_ctl(mod0)
  );

  pswallow_div #(.FIXED_LOG(4)) u_pswallow_div_fix (
    .clk(clk), .rst(rst), .en(1'b1), .n_val(11'd291), .a_val(7'd7),
    .mod_sel(mod_sel), .fp(fp1), .mod_ctl(mod1)
  );

  pswallow_ref #(.FIX_P(0)) u_ref0 (
    .clk(clk), .rst(rst), .en(en), .n(n_val), .a(a_val), .sel(mod_sel),
    .fp_e(efp0), .mod_e(emod0)
  );

  pswallow_ref #(.FIX_P(16)) u_ref1 (
    .clk(clk), .rst(rst), .en(1'b1), .n(11'd291), .a(7'd7), .sel(mod_sel),
    .fp_e(efp1), .mod_e(emod1)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the behavioural model
  always @(negedge clk) begin
    check(fp0 === efp0, cur_req, "fp vs model", int'(fp0), int'(efp0));
    check(mod0 === emod0, cur_req, "mod_ctl vs model", int'(mod0), int'(emod0));
    check(fp1 === efp1, "R9", "fixed fp vs model", int'(fp1), int'(efp1));
    check(mod1 === emod1, "R9", "fixed mod_ctl vs model", int'(mod1), int'(emod1));
  end

  function automatic logic fp_of(input int which);
    return (which == 0) ? fp0 : fp1;
  endfunction

  function automatic logic mod_of(input int which);
    return (which == 0) ? mod0 : mod1;
  endfunction

  // Measure one fp-to-fp interval; at_fp means the current falling edge already shows fp
  task automatic measure(input int which, input int exp_len, input int exp_mod,
                         input string req, input bit at_fp);
    int len = 0;
    int mh = 0;
    if (!at_fp) begin
      do @(negedge clk); while (fp_of(which) !== 1'b1);
    end
    do begin
      if (mod_of(which) === 1'b1) mh++;
      len++;
      @(negedge clk);
    end while (fp_of(which) !== 1'b1);
    check(len == exp_len, req, "period length", len, exp_len);
    if (exp_mod >= 0) check(mh == exp_mod, req, "mod_ctl high cycles", mh, exp_mod);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    checks++;
    $display("FAIL watchdog expired in %s actual=hung expected=finished", cur_req);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int pause_len;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(fp0 === 1'b0 && mod0 === 1'b0, "R1", "outputs in reset", int'(fp0), 0);
    rst = 1'b0;
    en = 1'b1;
    @(negedge clk);
    check(fp0 === 1'b0, "R1", "no pulse on first load", int'(fp0), 0);
    check(mod0 === 1'b1, "R1", "mod_ctl after first load with A=3", int'(mod0), 1);

    // R2 and R4: P=64, N=10, A=3
    cur_req = "R2";
    measure(0, 643, 195, "R2", 0);
    cur_req = "R4";
    measure(0, 643, 195, "R4", 1);

    // R6 then R3: change mid-period, old period finishes first
    n_val = 11'd7; a_val = 7'd2; mod_sel = 1'b0;
    cur_req = "R6";
    @(negedge clk);
    begin
      int len = 1;
      while (fp0 !== 1'b1) begin len++; @(negedge clk); end
      check(len == 643, "R6", "old period after mid change", len, 643);
    end
    cur_req = "R3";
    measure(0, 898, 258, "R3", 1);

    // R5: A = 0
    n_val = 11'd20; a_val = 7'd0; mod_sel = 1'b1;
    cur_req = "R6";
    measure(0, 898, 258, "R6", 1);
    cur_req = "R5";
    measure(0, 1280, 0, "R5", 1);

    // R7: pause inside a period
    cur_req = "R7";
    pause_len = 0;
    begin
      int len = 0;
      do begin
        len++;
        if (len == 100) en = 1'b0;
        if (len == 137) en = 1'b1;
        if (en == 1'b0 && fp0 === 1'b1) pause_len++;
        @(negedge clk);
      end while (fp0 !== 1'b1);
      check(len == 1317, "R7", "period with 37 disabled cycles", len, 1317);
      check(pause_len == 0, "R7", "pulses while disabled", pause_len, 0);
    end

    // R8: edge settings
    n_val = 11'd5; a_val = 7'd4; mod_sel = 1'b0;
    cur_req = "R8";
    measure(0, 1280, 0, "R8", 1);
    measure(0, 644, 516, "R8", 1);
    n_val = 11'd128; a_val = 7'd127; mod_sel = 1'b1;
    measure(0, 644, 516, "R8", 1);
    measure(0, 8319, 8255, "R8", 1);

    // R9: fixed 16/17 build
    cur_req = "R9";
    measure(1, 4663, 119, "R9", 0);

    // R1: reset mid-run clears outputs
    cur_req = "R1";
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(fp0 === 1'b0 && mod0 === 1'b0, "R1", "outputs after mid-run reset", int'(mod0), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule